// File: doc/BRIEF.md
# Digitally Calibrated RTC Prescaler

This block turns the 32.768 kHz oscillator clock into the once-per-second tick that advances the calendar. Crystals drift, so the block applies a signed digital trim. It either drops oscillator cycles (the divider stays put for one cycle) or adds divider steps (the divider advances by two for one cycle). These trim events are spread evenly across a fixed trim window of input cycles.

To find the needed trim, software turns on calibration mode. A shared output pin then carries a nominal 512 Hz square wave. This wave is taken from an untrimmed divider, so an external counter sees the raw oscillator error. Software converts that error into a 5-bit magnitude and a direction bit. It writes them while calibration mode is on, then leaves the mode. The pin returns to the power-fail indication and the trim stays in force.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: After reset, both registers read back as zero, no trim is applied and the pin carries the power-fail input.
- R2: With a trim magnitude of zero, the tick arrives exactly once every 2^DIV_W input cycles.
- R3: The tick is a pulse one input cycle wide, raised after the DIV_W-bit divider wraps.
- R4: With direction bit 0, any run of 2^WIN_W input cycles contains exactly |CAL| cycles in which the divider does not advance. These are spread evenly, so any shorter span of L cycles holds about L·|CAL|/2^WIN_W of them.
- R5: With direction bit 1, any run of 2^WIN_W input cycles contains exactly |CAL| cycles in which the divider advances by two. These are spread evenly in the same way as in R4.
- R6: While the enable bit is 1, the pin carries a square wave with a period of 2^(RAW_BIT+1) input cycles, which is 512 Hz at the defaults. The trim does not affect this wave.
- R7: While the enable bit is 0, the pin equals the power-fail input.
- R8: A write to the trim register while the enable bit is 0 is ignored. Its readback and the tick rate stay unchanged.
- R9: The register map uses address 0 for control and address 1 for trim. At address 0, bit 0 is the enable bit. At address 1, bits 4:0 hold the magnitude and bit 5 holds the direction (1 adds steps). Bits that are not used read as 0. Writes take effect on the next clock edge.
- R10: Clearing the enable bit keeps the trim value, and the trim stays applied to the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset (loss of backup supply) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 trim |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| pfail_i | input | 1 | Power-fail indication routed to the pin outside calibration |
| pin_o | output | 1 | Shared pin: 512 Hz wave or power-fail |
| tick_o | output | 1 | Trimmed one-second tick pulse |

## Verification
The assertions assume that register writes arrive synchronously with the oscillator clock. They also assume that the trim magnitude is constant over each cycle it is used, so every divider step can be tied to the magnitude held one cycle earlier. The stimulus drives all inputs on the falling edge, writes at most one register per cycle, and changes the trim only when a new measurement is about to begin. Each measured span therefore sees one fixed magnitude and direction. The bench uses a small divider and trim window, which keeps whole trim windows short enough to measure many times.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int MAG_W   = 5;
  localparam int DATA_W  = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_TRIM = 1'b1;
  localparam int SIGN_BIT = MAG_W;

  typedef struct packed {
    logic             add;
    logic [MAG_W-1:0] mag;
  } trim_t;
endpackage

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cal_en_o,
  output trim_t             trim_o
);
  localparam int PAD_W = DATA_W - MAG_W - 1;

  logic  cal_en_q;
  trim_t trim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_en_q <= 1'b0;
      trim_q   <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_CTRL) cal_en_q <= wdata_i[0];
      // trim is locked outside calibration mode
      else if (cal_en_q) trim_q <= trim_t'(wdata_i[SIGN_BIT:0]);
    end
  end

  always_comb begin
    if (addr_i == ADDR_CTRL) rdata_o = {{(DATA_W-1){1'b0}}, cal_en_q};
    else                     rdata_o = {{PAD_W{1'b0}}, trim_q};
  end

  assign cal_en_o = cal_en_q;
  assign trim_o   = trim_q;
endmodule

// File: rtl/rtc_cal_spread.sv
module rtc_cal_spread
  import rtc_cal_pkg::*;
#(
  parameter int WIN_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  output logic             evt_o
);
  // Phase accumulator: exactly mag carries per 2^WIN_W cycles, evenly spaced
  logic [WIN_W-1:0] acc_q;
  logic [WIN_W:0]   sum;

  assign sum   = {1'b0, acc_q} + (WIN_W+1)'(mag_i);
  assign evt_o = sum[WIN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[WIN_W-1:0];
  end
endmodule

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider #(
  parameter int DIV_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             add_i,
  output logic [DIV_W-1:0] div_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   sum;
  logic [1:0]       step;
  logic             tick_q;

  always_comb begin
    if (!evt_i)     step = 2'd1;
    else if (add_i) step = 2'd2;
    else            step = 2'd0;
  end

  assign sum = {1'b0, div_q} + (DIV_W+1)'(step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= sum[DIV_W-1:0];
      tick_q <= sum[DIV_W];
    end
  end

  assign div_o  = div_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/rtc_cal_raw_div.sv
module rtc_cal_raw_div #(
  parameter int RAW_BIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic wave_o
);
  logic [RAW_BIT:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign wave_o = cnt_q[RAW_BIT];
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int DIV_W   = 15,
  parameter int WIN_W   = 18,
  parameter int RAW_BIT = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       pfail_i,
  output logic       pin_o,
  output logic       tick_o
);
  logic             cal_en;
  trim_t            trim;
  logic             evt;
  logic             cal_wave;
  logic [DIV_W-1:0] div;

  rtc_cal_regs u_regs (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cal_en_o(cal_en),
    .trim_o  (trim)
  );

  rtc_cal_spread #(.WIN_W(WIN_W)) u_spread (
    .clk_i, .rst_ni,
    .mag_i(trim.mag),
    .evt_o(evt)
  );

  rtc_cal_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .evt_i (evt),
    .add_i (trim.add),
    .div_o (div),
    .tick_o(tick_o)
  );

  rtc_cal_raw_div #(.RAW_BIT(RAW_BIT)) u_raw (
    .clk_i, .rst_ni,
    .wave_o(cal_wave)
  );

  assign pin_o = cal_en ? cal_wave : pfail_i;
endmodule

// File: rtl/rtc_cal_prescaler_chk.sv
module rtc_cal_prescaler_chk
  import rtc_cal_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             reg_addr_i,
  input logic             cal_en,
  input trim_t            trim,
  input logic [DIV_W-1:0] div,
  input logic             pfail_i,
  input logic             pin_o,
  input logic             tick_o
);
  logic [DIV_W-1:0] prev_div;
  logic             prev_zero;
  logic             prev_valid;
  logic [DIV_W-1:0] delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_div   <= '0;
      prev_zero  <= 1'b1;
      prev_valid <= 1'b0;
    end else begin
      prev_div   <= div;
      prev_zero  <= (trim.mag == '0);
      prev_valid <= 1'b1;
    end
  end

  assign delta = div - prev_div;

  // R3
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R8
  trim_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_TRIM && !cal_en) |=> $stable(trim));

  // R7
  pin_pfail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_en |-> pin_o == pfail_i);

  // R2
  plain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_valid && prev_zero) |-> delta == DIV_W'(1));

  // R4
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_valid |-> delta <= DIV_W'(2));
endmodule

bind rtc_cal_prescaler rtc_cal_prescaler_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i,
  .cal_en(cal_en), .trim(trim), .div(div),
  .pfail_i, .pin_o, .tick_o
);

// File: tb/tb_rtc_cal_prescaler.sv
module tb_rtc_cal_prescaler;
  localparam int DIV_W   = 10;
  localparam int WIN_W   = 12;
  localparam int RAW_BIT = 5;
  localparam int PERIOD  = 1 << DIV_W;
  localparam int WIN     = 1 << WIN_W;
  localparam int HALF    = 1 << RAW_BIT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, addr = 1'b0, pfail = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic pin, tick;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  rtc_cal_prescaler #(.DIV_W(DIV_W), .WIN_W(WIN_W), .RAW_BIT(RAW_BIT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pfail_i(pfail),
    .pin_o(pin), .tick_o(tick));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    @(negedge clk); addr = a; #1 v = int'(rdata);
  endtask

  // cycles spanned by n ticks, starting at a tick
  task automatic span(input int n, output int len);
    int seen = 0;
    bit last = 0;
    do @(negedge clk); while (!tick);
    len = 0;
    last = 1;
    while (seen < n) begin
      @(negedge clk);
      len++;
      if (tick) begin
        chk(!last, "R3", 1, 0);
        seen++;
      end
      last = tick;
    end
  endtask

  function automatic bit near(input int evts, input int len, input int mag);
    int e = (len * mag) / WIN;
    return (evts >= e - 2) && (evts <= e + 2);
  endfunction

  task automatic rate(input int n, input int mag, input bit add, input string req);
    int len, evts;
    span(n, len);
    if (mag == 0) chk(len == n * PERIOD, req, len, n * PERIOD);
    else begin
      evts = add ? (n * PERIOD - len) : (len - n * PERIOD);
      chk(near(evts, len, mag), req, evts, (len * mag) / WIN);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  initial begin
    int v, prev, lvl, t;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(1'b1, v); chk(v == 0, "R1 trim", v, 0);
    pfail = 1'b1; #1 chk(pin == 1'b1, "R1 pin", pin, 1);
    pfail = 1'b0; #1 chk(pin == 1'b0, "R1 pin", pin, 0);

    // R2 untrimmed period, R3 pulse width
    rate(2, 0, 0, "R2");

    // R8 write ignored while disabled
    wr(1'b1, 8'h2A);
    rd(1'b1, v); chk(v == 0, "R8 readback", v, 0);
    rate(1, 0, 0, "R8 rate");

    // R9 enable and trim format
    wr(1'b0, 8'h01);
    rd(1'b0, v); chk(v == 1, "R9 ctrl", v, 1);
    wr(1'b1, 8'hD4);  // sign 0, mag 20, upper bits dropped
    rd(1'b1, v); chk(v == 8'h14, "R9 trim", v, 8'h14);

    // R6 pin wave unaffected by trim
    @(negedge clk); lvl = pin; t = 0;
    while (pin == lvl) begin @(negedge clk); end
    for (int k = 0; k < 4; k++) begin
      lvl = pin; t = 0;
      while (pin == lvl) begin @(negedge clk); t++; end
      chk(t == HALF, "R6 half period", t, HALF);
    end

    // R4 removal
    rate(8, 20, 0, "R4");

    // R10 leave calibration, trim kept
    wr(1'b0, 8'h00);
    rd(1'b1, v); chk(v == 8'h14, "R10 readback", v, 8'h14);
    pfail = 1'b1; #1 chk(pin == 1'b1, "R7 pin", pin, 1);
    rate(8, 20, 0, "R10 rate");

    // R8 locked write keeps old trim
    wr(1'b1, 8'h3F);
    rd(1'b1, v); chk(v == 8'h14, "R8 locked", v, 8'h14);

    // R5 insertion, max magnitude
    wr(1'b0, 8'h01); wr(1'b1, 8'h3F); wr(1'b0, 8'h00);
    rd(1'b1, v); chk(v == 8'h3F, "R9 trim max", v, 8'h3F);
    rate(8, 31, 1, "R5");

    // random trims and pin levels
    for (int i = 0; i < 6; i++) begin
      int m = 1 + ($urandom % 31);
      bit s = $urandom % 2;
      wr(1'b0, 8'h01);
      wr(1'b1, {2'b00, s, m[4:0]});
      wr(1'b0, 8'h00);
      pfail = $urandom % 2; #1
      chk(pin == pfail, "R7 random", pin, pfail);
      rate(4, m, s, s ? "R5 random" : "R4 random");
    end

    // R2 back to zero trim
    wr(1'b0, 8'h01); wr(1'b1, 8'h20); wr(1'b0, 8'h00);
    span(1, prev);
    rate(2, 0, 1, "R2 zero after trim");

    finish_run();
  end
endmodule